// File: doc/BRIEF.md
# Wishbone Down-Sizing Memory Port Bridge

This block sits on the slave side of a classic Wishbone bus. It turns each single read or write cycle into transfers on a narrower (or equally wide) native memory port. That port has three handshaked channels: a command channel (valid, ready, write flag, word address), a write-data channel (valid, ready, data, byte enables) and a read-data channel (valid, ready, data). The bus data width is an integer multiple of the port width. One bus word is cut into RATIO = BUS_DW / PORT_DW port beats at consecutive port addresses, and the least significant slice goes first.

A byte-specified base address is removed from incoming word addresses before they are scaled into port addresses. Read beats may return after any delay, and the bridge holds the bus cycle until the last beat has arrived. Only one bus transaction is in flight at a time. Elaboration stops with an error if the port is wider than the bus, if the widths are not a clean multiple of each other, or if the base is not aligned to a bus word.

Top module: `wb2mem_bridge`

## Requirements
- R1: After reset, wb_ack, cmd_valid, wd_valid and rd_ready are all low.
- R2: A bus write to word address A issues exactly RATIO commands with cmd_we high, in ascending order, at port addresses (A - BASE_BYTES/(BUS_DW/8)) * RATIO + i for beat i = 0..RATIO-1.
- R3: Write beat i carries bits [i*PORT_DW +: PORT_DW] of wb_dat_w, so the lowest slice goes to the lowest port address.
- R4: Bit j of wd_be on beat i equals wb_sel bit i*(PORT_DW/8)+j. A full select gives all-ones byte enables, and a partial select leaves the other port bytes untouched.
- R5: wb_ack pulses high for exactly one cycle per transaction, and for a write only after the last write-data beat has been accepted.
- R6: A bus read issues RATIO commands with cmd_we low at the same addresses as R2. It places read beat i in wb_dat_r bits [i*PORT_DW +: PORT_DW] and raises wb_ack only after the last beat is accepted, whatever the return latency.
- R7: The base is given in bytes: a bus access to word BASE_BYTES/(BUS_DW/8) reaches port address 0.
- R8: wb_stb without wb_cyc starts nothing: no command is issued and no ack is returned.
- R9: cmd_valid, cmd_addr and cmd_we stay unchanged while a command waits for cmd_ready. A transaction issues no command beyond its RATIO beats before its ack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_cyc | input | 1 | Bus cycle active |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Bus write flag |
| wb_adr | input | ADR_W | Bus word address |
| wb_dat_w | input | BUS_DW | Bus write data |
| wb_sel | input | BUS_DW/8 | Bus byte selects |
| wb_dat_r | output | BUS_DW | Bus read data |
| wb_ack | output | 1 | Bus acknowledge |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command accepted |
| cmd_we | output | 1 | Command is a write |
| cmd_addr | output | ADR_W | Port word address |
| wd_valid | output | 1 | Write data valid |
| wd_ready | input | 1 | Write data accepted |
| wd_data | output | PORT_DW | Write data beat |
| wd_be | output | PORT_DW/8 | Write byte enables |
| rd_valid | input | 1 | Read data valid |
| rd_ready | output | 1 | Read data accepted |
| rd_data | input | PORT_DW | Read data beat |

## Verification
The bench builds the bridge with a 64-bit bus, a 32-bit port and a base of 0x1000_0000 bytes. This gives a two-beat split, so beat ordering, slice placement and byte-enable splitting can all be observed. The non-zero base makes the subtraction visible as small port addresses. A port responder with adjustable handshake and return latency stalls commands, write data and read data. This exercises the hold rules and the rule that ack follows the last beat.

// File: rtl/wb2mem_pkg.sv
package wb2mem_pkg;

   typedef enum logic [2:0] {
      SEQ_IDLE  = 3'd0,
      SEQ_CMD   = 3'd1,
      SEQ_WDATA = 3'd2,
      SEQ_RDATA = 3'd3,
      SEQ_ACK   = 3'd4
   } seq_state_e;

   function automatic int beat_bits(input int ratio);
      return (ratio > 1) ? $clog2(ratio) : 1;
   endfunction

endpackage

// File: rtl/wb2mem_addr_map.sv
module wb2mem_addr_map #(
   parameter int          ADR_W     = 30,
   parameter int          RATIO     = 2,
   parameter int          BEAT_W    = 1,
   parameter logic [63:0] BASE_WORD = 64'h0
) (
   input  logic [ADR_W-1:0]  bus_adr,
   input  logic [BEAT_W-1:0] beat,
   output logic [ADR_W-1:0]  port_adr
);
   localparam logic [ADR_W-1:0] BASE_A  = BASE_WORD[ADR_W-1:0];
   localparam logic [ADR_W-1:0] SCALE_A = ADR_W'(RATIO);

   logic [ADR_W-1:0] rel_adr;

   assign rel_adr = bus_adr - BASE_A;

   generate
      if (RATIO == 1) begin : g_same_width
         logic beat_unused;
         assign beat_unused = ^beat;
         assign port_adr    = rel_adr;
      end else begin : g_scaled
         logic [ADR_W-1:0] scaled;
         assign scaled   = rel_adr * SCALE_A;
         assign port_adr = scaled + ADR_W'(beat);
      end
   endgenerate
endmodule

// File: rtl/wb2mem_lane_mux.sv
module wb2mem_lane_mux #(
   parameter int BUS_DW  = 64,
   parameter int PORT_DW = 32,
   parameter int BEAT_W  = 1
) (
   input  logic [BUS_DW-1:0]      bus_dat,
   input  logic [BUS_DW/8-1:0]    bus_sel,
   input  logic [BEAT_W-1:0]      beat,
   output logic [PORT_DW-1:0]     port_dat,
   output logic [PORT_DW/8-1:0]   port_be
);
   localparam int RATIO      = BUS_DW / PORT_DW;
   localparam int PORT_BYTES = PORT_DW / 8;

   generate
      if (RATIO == 1) begin : g_pass
         logic beat_unused;
         assign beat_unused = ^beat;
         assign port_dat    = bus_dat;
         assign port_be     = bus_sel;
      end else begin : g_split
         logic [PORT_DW-1:0]    dat_slice [RATIO];
         logic [PORT_BYTES-1:0] be_slice  [RATIO];
         for (genvar g = 0; g < RATIO; g++) begin : g_lane
            assign dat_slice[g] = bus_dat[g*PORT_DW +: PORT_DW];
            assign be_slice[g]  = bus_sel[g*PORT_BYTES +: PORT_BYTES];
         end
         assign port_dat = dat_slice[beat];
         assign port_be  = be_slice[beat];
      end
   endgenerate
endmodule

// File: rtl/wb2mem_read_gather.sv
module wb2mem_read_gather #(
   parameter int BUS_DW  = 64,
   parameter int PORT_DW = 32,
   parameter int BEAT_W  = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take,
   input  logic [BEAT_W-1:0]  beat,
   input  logic [PORT_DW-1:0] beat_dat,
   output logic [BUS_DW-1:0]  word
);
   localparam int RATIO = BUS_DW / PORT_DW;

   generate
      for (genvar g = 0; g < RATIO; g++) begin : g_lane
         logic [PORT_DW-1:0] lane_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               lane_q <= '0;
            end else if (take && (beat == BEAT_W'(g))) begin
               lane_q <= beat_dat;
            end
         end
         assign word[g*PORT_DW +: PORT_DW] = lane_q;
      end
   endgenerate
endmodule

// File: rtl/wb2mem_seq.sv
module wb2mem_seq
   import wb2mem_pkg::*;
#(
   parameter int RATIO  = 2,
   parameter int BEAT_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              is_write,
   input  logic              cmd_ready,
   input  logic              wd_ready,
   input  logic              rd_valid,
   output logic              start,
   output logic              cmd_valid,
   output logic              wd_valid,
   output logic              rd_ready,
   output logic              bus_ack,
   output logic [BEAT_W-1:0] beat
);
   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(RATIO - 1);

   seq_state_e        state_q, state_d;
   logic [BEAT_W-1:0] beat_q, beat_d;
   logic              beat_done;

   assign start     = (state_q == SEQ_IDLE) && bus_req;
   assign cmd_valid = (state_q == SEQ_CMD);
   assign wd_valid  = (state_q == SEQ_WDATA);
   assign rd_ready  = (state_q == SEQ_RDATA);
   assign bus_ack   = (state_q == SEQ_ACK);
   assign beat      = beat_q;
   assign beat_done = (wd_valid && wd_ready) || (rd_ready && rd_valid);

   always_comb begin
      state_d = state_q;
      beat_d  = beat_q;
      unique case (state_q)
         SEQ_IDLE: begin
            if (bus_req) begin
               state_d = SEQ_CMD;
               beat_d  = '0;
            end
         end
         SEQ_CMD: begin
            if (cmd_ready) state_d = is_write ? SEQ_WDATA : SEQ_RDATA;
         end
         SEQ_WDATA, SEQ_RDATA: begin
            if (beat_done) begin
               if (beat_q == LAST_BEAT) begin
                  state_d = SEQ_ACK;
               end else begin
                  state_d = SEQ_CMD;
                  beat_d  = beat_q + 1'b1;
               end
            end
         end
         SEQ_ACK:  state_d = SEQ_IDLE;
         default:  state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         beat_q  <= '0;
      end else begin
         state_q <= state_d;
         beat_q  <= beat_d;
      end
   end

   AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid); // R9
   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ack |=> !bus_ack); // R5
   AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_valid, wd_valid, rd_ready, bus_ack})); // R9
endmodule

// File: rtl/wb2mem_bridge.sv
module wb2mem_bridge #(
   parameter int          BUS_DW     = 64,
   parameter int          PORT_DW    = 32,
   parameter int          ADR_W      = 30,
   parameter logic [63:0] BASE_BYTES = 64'h0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wb_cyc,
   input  logic                  wb_stb,
   input  logic                  wb_we,
   input  logic [ADR_W-1:0]      wb_adr,
   input  logic [BUS_DW-1:0]     wb_dat_w,
   input  logic [BUS_DW/8-1:0]   wb_sel,
   output logic [BUS_DW-1:0]     wb_dat_r,
   output logic                  wb_ack,
   output logic                  cmd_valid,
   input  logic                  cmd_ready,
   output logic                  cmd_we,
   output logic [ADR_W-1:0]      cmd_addr,
   output logic                  wd_valid,
   input  logic                  wd_ready,
   output logic [PORT_DW-1:0]    wd_data,
   output logic [PORT_DW/8-1:0]  wd_be,
   input  logic                  rd_valid,
   output logic                  rd_ready,
   input  logic [PORT_DW-1:0]    rd_data
);
   localparam int          RATIO     = (PORT_DW > BUS_DW) ? 1 : BUS_DW / PORT_DW;
   localparam int          BEAT_W    = wb2mem_pkg::beat_bits(RATIO);
   localparam int          BUS_BYTES = BUS_DW / 8;
   localparam logic [63:0] BASE_WORD = BASE_BYTES / 64'(BUS_BYTES);

   generate
      if (PORT_DW > BUS_DW) begin : g_err_port_wide
         $error("port data width exceeds bus data width");
      end
      if ((BUS_DW % PORT_DW) != 0) begin : g_err_ratio
         $error("bus width is not a multiple of port width");
      end
      if ((PORT_DW % 8) != 0) begin : g_err_bytes
         $error("port width is not a whole number of bytes");
      end
      if ((BASE_BYTES % 64'(BUS_BYTES)) != 0) begin : g_err_base
         $error("base address is not aligned to a bus word");
      end
   endgenerate

   logic                  bus_req;
   logic                  start;
   logic [BEAT_W-1:0]     beat;
   logic [ADR_W-1:0]      adr_q;
   logic [BUS_DW-1:0]     dat_q;
   logic [BUS_DW/8-1:0]   sel_q;
   logic                  wr_q;

   assign bus_req = wb_cyc && wb_stb;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         adr_q <= '0;
         dat_q <= '0;
         sel_q <= '0;
         wr_q  <= 1'b0;
      end else if (start) begin
         adr_q <= wb_adr;
         dat_q <= wb_dat_w;
         sel_q <= wb_sel;
         wr_q  <= wb_we;
      end
   end

   wb2mem_seq #(.RATIO(RATIO), .BEAT_W(BEAT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_req   (bus_req),
      .is_write  (wr_q),
      .cmd_ready (cmd_ready),
      .wd_ready  (wd_ready),
      .rd_valid  (rd_valid),
      .start     (start),
      .cmd_valid (cmd_valid),
      .wd_valid  (wd_valid),
      .rd_ready  (rd_ready),
      .bus_ack   (wb_ack),
      .beat      (beat)
   );

   wb2mem_addr_map #(
      .ADR_W(ADR_W), .RATIO(RATIO), .BEAT_W(BEAT_W), .BASE_WORD(BASE_WORD)
   ) u_addr_map (
      .bus_adr  (adr_q),
      .beat     (beat),
      .port_adr (cmd_addr)
   );

   wb2mem_lane_mux #(.BUS_DW(BUS_DW), .PORT_DW(PORT_DW), .BEAT_W(BEAT_W)) u_lane_mux (
      .bus_dat  (dat_q),
      .bus_sel  (sel_q),
      .beat     (beat),
      .port_dat (wd_data),
      .port_be  (wd_be)
   );

   wb2mem_read_gather #(.BUS_DW(BUS_DW), .PORT_DW(PORT_DW), .BEAT_W(BEAT_W)) u_gather (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (rd_valid && rd_ready),
      .beat     (beat),
      .beat_dat (rd_data),
      .word     (wb_dat_r)
   );

   assign cmd_we = wr_q;

   AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> $stable(cmd_addr) && $stable(cmd_we)); // R9
   AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      wd_valid && !wd_ready |=> wd_valid && $stable(wd_data) && $stable(wd_be)); // R3
   AST_WR_ACK_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      wb_ack && cmd_we |-> $past(wd_valid && wd_ready)); // R5
   AST_RD_ACK_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      wb_ack && !cmd_we |-> $past(rd_valid && rd_ready)); // R6
   AST_NO_START_WITHOUT_CYC: assert property (@(posedge clk) disable iff (!rst_n)
      !wb_cyc && !(cmd_valid || wd_valid || rd_ready || wb_ack) |=> !cmd_valid); // R8
endmodule

// File: tb/wb2mem_bridge_bench.sv
`timescale 1ns/100ps
module wb2mem_bridge_bench;
   localparam int          BUS_DW  = 64;
   localparam int          PORT_DW = 32;
   localparam int          ADR_W   = 30;
   localparam logic [63:0] BASE_B  = 64'h1000_0000;
   localparam logic [ADR_W-1:0] BASE_W = ADR_W'(BASE_B / 8);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
   logic [ADR_W-1:0]   wb_adr = '0;
   logic [BUS_DW-1:0]  wb_dat_w = '0;
   logic [7:0]         wb_sel = '0;
   logic [BUS_DW-1:0]  wb_dat_r;
   logic               wb_ack;
   logic               cmd_valid, cmd_we;
   logic               cmd_ready = 1'b0;
   logic [ADR_W-1:0]   cmd_addr;
   logic               wd_valid;
   logic               wd_ready = 1'b0;
   logic [PORT_DW-1:0] wd_data;
   logic [3:0]         wd_be;
   logic               rd_valid = 1'b0;
   logic               rd_ready;
   logic [PORT_DW-1:0] rd_data = '0;

   always #2 clk = ~clk;

   wb2mem_bridge #(.BUS_DW(BUS_DW), .PORT_DW(PORT_DW), .ADR_W(ADR_W), .BASE_BYTES(BASE_B))
   u_wb2mem_bridge (
      .clk(clk), .rst_n(rst_n),
      .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
      .wb_dat_w(wb_dat_w), .wb_sel(wb_sel), .wb_dat_r(wb_dat_r), .wb_ack(wb_ack),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
      .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data), .wd_be(wd_be),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
   );

   int checks = 0;
   int errors = 0;
   int lat = 0;
   logic [31:0] mem [0:31];

   // handshake logs, sampled shortly before each rising edge
   logic [ADR_W-1:0] log_addr [0:7];
   logic             log_we   [0:7];
   logic [3:0]       log_be   [0:7];
   int n_cmd, n_wd, n_rd, n_ack, ack_wd, ack_rd, cv_cycles, hold_err;
   logic             pend_q = 1'b0;
   logic [ADR_W-1:0] pend_addr = '0;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic clear_logs;
      n_cmd = 0; n_wd = 0; n_rd = 0; n_ack = 0;
      ack_wd = -1; ack_rd = -1; cv_cycles = 0;
   endtask

   initial begin
      forever begin
         @(negedge clk);
         #1.5;
         if (!rst_n) continue;
         if (pend_q && !(cmd_valid && cmd_addr == pend_addr)) hold_err++;
         pend_q    = cmd_valid && !cmd_ready;
         pend_addr = cmd_addr;
         if (cmd_valid) cv_cycles++;
         if (cmd_valid && cmd_ready && n_cmd < 8) begin
            log_addr[n_cmd] = cmd_addr;
            log_we[n_cmd]   = cmd_we;
            n_cmd++;
         end
         if (wd_valid && wd_ready) begin
            if (n_wd < 8) log_be[n_wd] = wd_be;
            n_wd++;
         end
         if (rd_valid && rd_ready) n_rd++;
         if (wb_ack) begin
            n_ack++;
            ack_wd = n_wd;
            ack_rd = n_rd;
         end
      end
   end

   // port-side memory responder
   initial begin
      logic [ADR_W-1:0] a;
      logic             w;
      logic [31:0]      d;
      logic [3:0]       be;
      forever begin
         @(negedge clk);
         if (rst_n && cmd_valid) begin
            repeat (lat) @(negedge clk);
            a = cmd_addr; w = cmd_we;
            cmd_ready = 1'b1;
            @(negedge clk);
            cmd_ready = 1'b0;
            if (w) begin
               while (!wd_valid) @(negedge clk);
               repeat (lat) @(negedge clk);
               d = wd_data; be = wd_be;
               wd_ready = 1'b1;
               @(negedge clk);
               wd_ready = 1'b0;
               for (int b = 0; b < 4; b++)
                  if (be[b]) mem[a[4:0]][8*b +: 8] = d[8*b +: 8];
            end else begin
               repeat (lat) @(negedge clk);
               rd_valid = 1'b1;
               rd_data  = mem[a[4:0]];
               while (!rd_ready) @(negedge clk);
               @(negedge clk);
               rd_valid = 1'b0;
               rd_data  = '0;
            end
         end
      end
   end

   task automatic wb_xfer(input logic we, input logic [ADR_W-1:0] adr,
                          input logic [63:0] dat, input logic [7:0] sel,
                          output logic [63:0] rdat);
      int n;
      clear_logs();
      @(negedge clk);
      wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = we;
      wb_adr = adr; wb_dat_w = dat; wb_sel = sel;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!wb_ack && n < 400);
      if (n >= 400) check("bus transaction timeout", 64'd0, 64'd1);
      rdat = wb_dat_r;
      wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset;
      check("R1 wb_ack", 64'(wb_ack), 64'd0);
      check("R1 cmd_valid", 64'(cmd_valid), 64'd0);
      check("R1 wd_valid", 64'(wd_valid), 64'd0);
      check("R1 rd_ready", 64'(rd_ready), 64'd0);
   endtask

   task automatic t_write_full;
      logic [63:0] r;
      lat = 3;
      wb_xfer(1'b1, BASE_W, 64'h0d15ea5e_00facade, 8'hff, r);
      check("R2 command count", 64'(n_cmd), 64'd2);
      check("R2 beat0 address", 64'(log_addr[0]), 64'd0);
      check("R2 beat1 address", 64'(log_addr[1]), 64'd1);
      check("R2 write flag", {62'd0, log_we[0], log_we[1]}, 64'd3);
      check("R3 low slice at low address", 64'(mem[0]), 64'h00facade);
      check("R3 high slice at next address", 64'(mem[1]), 64'h0d15ea5e);
      check("R4 full enables", {56'd0, log_be[0], log_be[1]}, 64'hff);
      check("R5 single ack", 64'(n_ack), 64'd1);
      check("R5 ack after last write beat", 64'(ack_wd), 64'd2);
   endtask

   task automatic t_write_base;
      logic [63:0] r;
      lat = 1;
      wb_xfer(1'b1, BASE_W + 30'd5, 64'habadcafe_8badf00d, 8'hff, r);
      check("R7 base removed beat0 address", 64'(log_addr[0]), 64'd10);
      check("R7 base removed beat1 address", 64'(log_addr[1]), 64'd11);
      check("R3 word 5 low", 64'(mem[10]), 64'h8badf00d);
      check("R3 word 5 high", 64'(mem[11]), 64'habadcafe);
      wb_xfer(1'b1, BASE_W + 30'd2, 64'hfee1dead_deadc0de, 8'hff, r);
      check("R2 word 2 addresses", {32'(log_addr[0]), 32'(log_addr[1])}, {32'd4, 32'd5});
   endtask

   task automatic t_write_partial;
      logic [63:0] r;
      lat = 0;
      wb_xfer(1'b1, BASE_W + 30'd2, 64'h11112222_33334444, 8'h3c, r);
      check("R4 split enables", {56'd0, log_be[0], log_be[1]}, 64'hc3);
      check("R4 partial low word", 64'(mem[4]), 64'h3333c0de);
      check("R4 partial high word", 64'(mem[5]), 64'hfee12222);
      check("R2 partial still two beats", 64'(n_cmd), 64'd2);
   endtask

   task automatic t_read(input int l);
      logic [63:0] r;
      lat = l;
      wb_xfer(1'b0, BASE_W + 30'd2, '0, 8'hff, r);
      check("R6 read word 2 assembly", r, 64'hfee12222_3333c0de);
      check("R6 read command count", 64'(n_cmd), 64'd2);
      check("R6 read flag low", {62'd0, log_we[0], log_we[1]}, 64'd0);
      check("R6 read addresses", {32'(log_addr[0]), 32'(log_addr[1])}, {32'd4, 32'd5});
      check("R6 ack after last read beat", 64'(ack_rd), 64'd2);
      check("R5 single ack on read", 64'(n_ack), 64'd1);
      wb_xfer(1'b0, BASE_W + 30'd5, '0, 8'hff, r);
      check("R6 read word 5 assembly", r, 64'habadcafe_8badf00d);
   endtask

   task automatic t_stb_no_cyc;
      clear_logs();
      @(negedge clk);
      wb_cyc = 1'b0; wb_stb = 1'b1; wb_we = 1'b1; wb_adr = BASE_W;
      wb_dat_w = 64'hffff_ffff_ffff_ffff; wb_sel = 8'hff;
      repeat (20) @(negedge clk);
      wb_stb = 1'b0; wb_we = 1'b0;
      repeat (3) @(negedge clk);
      check("R8 no command without cyc", 64'(cv_cycles), 64'd0);
      check("R8 no ack without cyc", 64'(n_ack), 64'd0);
      check("R8 memory untouched", 64'(mem[0]), 64'h00facade);
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      hold_err = 0;
      for (int i = 0; i < 32; i++) mem[i] = '0;
      clear_logs();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_full();
      t_write_base();
      t_write_partial();
      t_read(0);
      t_read(7);
      t_stb_no_cyc();
      check("R9 command held until accepted", 64'(hold_err), 64'd0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule